// File: doc/BRIEF.md
# CEC Signal-Free-Time Scheduler

This block decides the moment at which a pending transmit request on a single-wire consumer-electronics control bus may begin driving its start bit. The bus requires a quiet interval after the last frame before any initiator begins, and the length of that interval sets transmit priority between competing devices. The scheduler counts that quiet interval in half-bit units. Each unit is one pulse of an external time tick, nominally 1.2 ms.

The interval can be fixed by a 3-bit setting. It can also be chosen automatically from the outcome of this device's last attempt. In automatic mode a failed attempt gets the shortest wait and therefore the highest priority. A device that has just finished successfully gets the longest wait. Any other device waits a middle length.

The count can start in one of two ways. It can start when the request is raised, or it can run ahead from the end of the previous bus activity. When it runs ahead, a request arriving after the interval has expired is launched without delay. The single output is a one-cycle go pulse that the bit-level transmitter uses to start the frame.

Top module: `cec_sft_sched`

## Requirements
- R1: With `sftCode` from 1 to 7, the go pulse follows exactly 2*`sftCode`-1 tick pulses after counting starts. For example, code 1 waits half a bit and code 7 waits six and a half bits.
- R2: With `sftCode` = 0, the interval is 10 ticks (five bit periods) after reset, after an `arbLost` outcome, and after the block has been re-enabled.
- R3: With `sftCode` = 0, the interval is 6 ticks after a `txFail` outcome and 14 ticks after a `txOk` outcome.
- R4: With `preCount` = 0, ticks that arrive while `txReq` is low are not counted. Counting starts when `txReq` rises.
- R5: With `preCount` = 1, counting starts on a `busIdle` or `frameEnd` pulse, whether or not a request is pending. If the interval has already elapsed when `txReq` rises, go fires within 2 clock cycles and no tick is needed. Without such a pulse, no count runs.
- R6: While `rxBusy` is high, the count is held at zero and go is withheld. Counting resumes from zero once `rxBusy` falls.
- R7: A `lineFall` pulse during counting restarts the count from zero.
- R8: Go is a single-cycle pulse. After a go, no further go occurs until a `txOk`, `txFail` or `arbLost` outcome pulse.
- R9: While `en` is low, go stays low and any pending count is cancelled. Disabling the block resets the history to the new-initiator state.
- R10: Go is only issued when, in the cycle before, `txReq` was high and `rxBusy` was low. Go is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable; low cancels the count and clears the history |
| tick | input | 1 | One-cycle pulse per half bit period |
| sftCode | input | 3 | 0 selects the automatic interval; 1..7 select 2k-1 half bits |
| preCount | input | 1 | 0 starts counting at the request; 1 starts it at the end of bus activity |
| txReq | input | 1 | Transmit request level, held until the attempt is resolved |
| rxBusy | input | 1 | Reception in progress |
| lineFall | input | 1 | Pulse on a falling edge of the bus line |
| busIdle | input | 1 | Pulse when bus idle or a line error is detected |
| frameEnd | input | 1 | Pulse at the end of the final bit of a frame |
| txOk | input | 1 | Pulse: last attempt completed successfully |
| txFail | input | 1 | Pulse: last attempt failed |
| arbLost | input | 1 | Pulse: last attempt lost arbitration |
| go | output | 1 | One-cycle permission to drive the start bit |

## Verification
The main function is exercised with random fixed and automatic codes. Each random attempt ends with a random outcome, and the bench's own history model predicts the exact number of ticks before go. This separates the seven fixed lengths from the three history-driven ones. Directed cases cover the following:
- pre-counting from a bus-idle pulse against counting from the request, which separates zero-latency launch from a fresh count;
- a line falling edge and an active reception in the middle of a count, which shows a restart from zero rather than a pause;
- disabling the block after a failure, which shows that the history is cleared.

// File: rtl/cec_sft_pkg.sv
package cec_sft_pkg;

  typedef enum logic [1:0] {
    HIST_NEW   = 2'd0,
    HIST_RETRY = 2'd1,
    HIST_DONE  = 2'd2
  } sftHist_t;

  typedef struct packed {
    logic clrCnt;
    logic incCnt;
  } sftStrobe_t;

endpackage

// File: rtl/cec_sft_ctrl.sv
module cec_sft_ctrl
  import cec_sft_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       en,
  input  logic       tick,
  input  logic       preCount,
  input  logic       txReq,
  input  logic       rxBusy,
  input  logic       lineFall,
  input  logic       busIdle,
  input  logic       frameEnd,
  input  logic       txOk,
  input  logic       txFail,
  input  logic       arbLost,
  input  logic       expired,
  output sftStrobe_t strb,
  output sftHist_t   hist,
  output logic       go
);

  logic running;
  logic inFlight;
  logic startEvt;
  logic fire;

  always_comb begin
    if (preCount) startEvt = busIdle | frameEnd;
    else          startEvt = txReq & ~running & ~rxBusy;
    startEvt    = startEvt & ~inFlight & en;
    fire        = en & running & txReq & ~rxBusy & ~inFlight & expired;
    strb.clrCnt = ~en | ~running | startEvt | lineFall | rxBusy | fire;
    strb.incCnt = en & running & tick;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist     <= HIST_NEW;
      running  <= 1'b0;
      inFlight <= 1'b0;
      go       <= 1'b0;
    end else if (!en) begin
      hist     <= HIST_NEW;
      running  <= 1'b0;
      inFlight <= 1'b0;
      go       <= 1'b0;
    end else begin
      go <= fire;
      if (txOk) begin
        hist     <= HIST_DONE;
        inFlight <= 1'b0;
      end else if (txFail) begin
        hist     <= HIST_RETRY;
        inFlight <= 1'b0;
      end else if (arbLost) begin
        hist     <= HIST_NEW;
        inFlight <= 1'b0;
      end
      if (fire) begin
        running  <= 1'b0;
        inFlight <= 1'b1;
      end else if (startEvt) begin
        running <= 1'b1;
      end else if (!preCount && !txReq) begin
        running <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cec_sft_count.sv
module cec_sft_count
  import cec_sft_pkg::*;
#(
  parameter int CODE_W     = 3,
  parameter int CNT_W      = 4,
  parameter int RETRY_HALF = 6,
  parameter int NEW_HALF   = 10,
  parameter int DONE_HALF  = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  sftStrobe_t        strb,
  input  sftHist_t          hist,
  input  logic [CODE_W-1:0] sftCode,
  output logic              expired
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] thr;

  always_comb begin
    if (sftCode == '0) begin
      case (hist)
        HIST_RETRY: thr = CNT_W'(RETRY_HALF);
        HIST_DONE:  thr = CNT_W'(DONE_HALF);
        default:    thr = CNT_W'(NEW_HALF);
      endcase
    end else begin
      thr = CNT_W'({sftCode, 1'b0}) - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              cnt <= '0;
    else if (strb.clrCnt)                   cnt <= '0;
    else if (strb.incCnt && cnt != CNT_MAX) cnt <= cnt + CNT_W'(1);
  end

  assign expired = (cnt >= thr);

endmodule

// File: rtl/cec_sft_sched.sv
module cec_sft_sched
  import cec_sft_pkg::*;
#(
  parameter int CODE_W     = 3,
  parameter int RETRY_HALF = 6,
  parameter int NEW_HALF   = 10,
  parameter int DONE_HALF  = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic              tick,
  input  logic [CODE_W-1:0] sftCode,
  input  logic              preCount,
  input  logic              txReq,
  input  logic              rxBusy,
  input  logic              lineFall,
  input  logic              busIdle,
  input  logic              frameEnd,
  input  logic              txOk,
  input  logic              txFail,
  input  logic              arbLost,
  output logic              go
);

  localparam int FIX_MAX  = 2 * (2 ** CODE_W) - 1;
  localparam int AUTO_MAX = (DONE_HALF > NEW_HALF) ?
                            ((DONE_HALF > RETRY_HALF) ? DONE_HALF : RETRY_HALF) :
                            ((NEW_HALF > RETRY_HALF) ? NEW_HALF : RETRY_HALF);
  localparam int HALF_MAX = (FIX_MAX > AUTO_MAX) ? FIX_MAX : AUTO_MAX;
  localparam int CNT_W    = $clog2(HALF_MAX + 1);

  sftStrobe_t strb;
  sftHist_t   hist;
  logic       expired;

  cec_sft_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .en(en), .tick(tick), .preCount(preCount),
    .txReq(txReq), .rxBusy(rxBusy), .lineFall(lineFall), .busIdle(busIdle),
    .frameEnd(frameEnd), .txOk(txOk), .txFail(txFail), .arbLost(arbLost),
    .expired(expired), .strb(strb), .hist(hist), .go(go)
  );

  cec_sft_count #(
    .CODE_W(CODE_W), .CNT_W(CNT_W), .RETRY_HALF(RETRY_HALF),
    .NEW_HALF(NEW_HALF), .DONE_HALF(DONE_HALF)
  ) count_i (
    .clk(clk), .rstN(rstN), .strb(strb), .hist(hist),
    .sftCode(sftCode), .expired(expired)
  );

endmodule

// File: rtl/cec_sft_sched_chk.sv
module cec_sft_sched_chk (
  input logic clk,
  input logic rstN,
  input logic en,
  input logic txReq,
  input logic rxBusy,
  input logic txOk,
  input logic txFail,
  input logic arbLost,
  input logic go
);

  logic attemptOpen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          attemptOpen <= 1'b0;
    else if (!en)                       attemptOpen <= 1'b0;
    else if (txOk || txFail || arbLost) attemptOpen <= 1'b0;
    else if (go)                        attemptOpen <= 1'b1;
  end

  p_go_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    go |=> !go);

  p_one_per_try_r8: assert property (@(posedge clk) disable iff (!rstN)
    go |-> !attemptOpen);

  p_go_gated_r10: assert property (@(posedge clk) disable iff (!rstN)
    go |-> $past(txReq && !rxBusy));

  p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> !go);

endmodule

bind cec_sft_sched cec_sft_sched_chk chk_i (
  .clk(clk), .rstN(rstN), .en(en), .txReq(txReq), .rxBusy(rxBusy),
  .txOk(txOk), .txFail(txFail), .arbLost(arbLost), .go(go)
);

// File: tb/cec_sft_sched_tb.sv
`timescale 1ns/1ps
module cec_sft_sched_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       en = 1'b0;
  logic       tick = 1'b0;
  logic [2:0] sftCode = 3'd0;
  logic       preCount = 1'b0;
  logic       txReq = 1'b0;
  logic       rxBusy = 1'b0;
  logic       lineFall = 1'b0;
  logic       busIdle = 1'b0;
  logic       frameEnd = 1'b0;
  logic       txOk = 1'b0;
  logic       txFail = 1'b0;
  logic       arbLost = 1'b0;
  logic       go;

  int checks = 0;
  int fails = 0;
  int tickCnt = 0;
  int goHits = 0;
  int goTick = -1;
  int modelHist = 0;
  bit done = 0;

  cec_sft_sched dut_i (
    .clk(clk), .rstN(rstN), .en(en), .tick(tick), .sftCode(sftCode),
    .preCount(preCount), .txReq(txReq), .rxBusy(rxBusy), .lineFall(lineFall),
    .busIdle(busIdle), .frameEnd(frameEnd), .txOk(txOk), .txFail(txFail),
    .arbLost(arbLost), .go(go)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (tick) tickCnt++;
    if (go) begin
      goHits++;
      goTick = tickCnt;
    end
  end

  function automatic int expThr(int code, int h);
    if (code != 0) return 2 * code - 1;
    if (h == 1) return 6;
    if (h == 2) return 14;
    return 10;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic tickOnce();
    idle(3);
    tick = 1'b1;
    idle(1);
    tick = 1'b0;
    idle(4);
  endtask

  task automatic runUntilGo(int limit);
    int startHits = goHits;
    for (int i = 0; i < limit && goHits == startHits; i++) tickOnce();
  endtask

  // kind 0 ok, 1 fail, 2 arbitration lost
  task automatic outcome(int kind);
    if (kind == 0) txOk = 1'b1;
    else if (kind == 1) txFail = 1'b1;
    else arbLost = 1'b1;
    idle(1);
    txOk = 1'b0; txFail = 1'b0; arbLost = 1'b0;
    modelHist = (kind == 0) ? 2 : ((kind == 1) ? 1 : 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    int h0;
    int code;
    int kind;
    void'($urandom(32'h00c0ffee));
    idle(3);
    check(go == 1'b0, "R10 reset", int'(go), 0);
    rstN = 1'b1;
    en = 1'b1;
    idle(2);

    // R4: ticks before the request are not counted
    sftCode = 3'd2;
    idle(1);
    repeat (8) tickOnce();
    h0 = goHits;
    txReq = 1'b1; tickCnt = 0;
    runUntilGo(20);
    check(goHits == h0 + 1 && goTick == 3, "R4 count from request", goTick, 3);
    outcome(0);
    txReq = 1'b0;
    idle(2);

    // R8: no second go while the attempt is open
    sftCode = 3'd1;
    txReq = 1'b1; tickCnt = 0;
    runUntilGo(20);
    h0 = goHits;
    repeat (20) tickOnce();
    check(goHits == h0, "R8 single go per attempt", goHits - h0, 0);
    outcome(2);
    txReq = 1'b0;
    idle(2);

    // R7: a falling edge restarts the count
    sftCode = 3'd3;
    h0 = goHits;
    txReq = 1'b1; tickCnt = 0;
    repeat (3) tickOnce();
    lineFall = 1'b1; idle(1); lineFall = 1'b0;
    tickCnt = 0;
    runUntilGo(20);
    check(goHits == h0 + 1 && goTick == 5, "R7 restart on falling edge", goTick, 5);
    outcome(0);
    txReq = 1'b0;
    idle(2);

    // R6: request held during reception
    sftCode = 3'd2;
    rxBusy = 1'b1;
    txReq = 1'b1;
    h0 = goHits;
    repeat (8) tickOnce();
    check(goHits == h0, "R6 held during reception", goHits - h0, 0);
    rxBusy = 1'b0; tickCnt = 0;
    runUntilGo(20);
    check(goHits == h0 + 1 && goTick == 3, "R6 count after reception", goTick, 3);
    outcome(1);
    txReq = 1'b0;
    idle(2);

    // R5: pre-count from bus idle, zero-latency launch
    preCount = 1'b1;
    sftCode = 3'd2;
    idle(1);
    busIdle = 1'b1; idle(1); busIdle = 1'b0;
    tickCnt = 0;
    h0 = goHits;
    repeat (4) tickOnce();
    check(goHits == h0, "R10 no go without request", goHits - h0, 0);
    txReq = 1'b1;
    idle(3);
    check(goHits == h0 + 1 && goTick == 4, "R5 zero-latency go", goTick, 4);
    outcome(0);
    h0 = goHits;
    repeat (6) tickOnce();
    check(goHits == h0, "R5 no count without bus event", goHits - h0, 0);
    frameEnd = 1'b1; idle(1); frameEnd = 1'b0;
    tickCnt = 0;
    runUntilGo(20);
    check(goHits == h0 + 1 && goTick == 3, "R5 count from frame end", goTick, 3);
    outcome(0);
    txReq = 1'b0;
    preCount = 1'b0;
    idle(2);

    // R9: disable cancels and resets history
    sftCode = 3'd0;
    txReq = 1'b1; tickCnt = 0;
    runUntilGo(20);
    outcome(1);
    txReq = 1'b0;
    en = 1'b0;
    idle(2);
    modelHist = 0;
    sftCode = 3'd1;
    txReq = 1'b1;
    h0 = goHits;
    repeat (4) tickOnce();
    check(goHits == h0, "R9 quiet while disabled", goHits - h0, 0);
    txReq = 1'b0;
    idle(1);
    en = 1'b1;
    sftCode = 3'd0;
    idle(1);
    txReq = 1'b1; tickCnt = 0;
    runUntilGo(20);
    check(goHits == h0 + 1 && goTick == 10, "R9 R2 history cleared", goTick, 10);
    outcome(0);
    txReq = 1'b0;
    idle(2);

    // R1 R2 R3: random codes and outcomes
    for (int it = 0; it < 40; it++) begin
      code = $urandom_range(0, 7);
      sftCode = code[2:0];
      idle(1);
      h0 = goHits;
      txReq = 1'b1; tickCnt = 0;
      runUntilGo(20);
      check(goHits == h0 + 1 && goTick == expThr(code, modelHist),
            (code != 0) ? "R1 fixed interval" : "R2 R3 automatic interval",
            goTick, expThr(code, modelHist));
      kind = $urandom_range(0, 2);
      outcome(kind);
      txReq = 1'b0;
      idle(2);
    end

    finishRun();
  end

endmodule